// File: doc/BRIEF.md
# Best-Four Candidate Sorter

The block takes 36 candidate keys every clock and reports the four strongest, strongest first. Each key is a 7-bit unsigned value. The momentum field (5 bits) sits above the quality field (2 bits), so comparing whole keys as integers ranks by momentum first and uses quality to break equal momenta. A key of zero marks an empty candidate. Each output slot gives the winner's key, its candidate number (0 to 35) and a valid flag.

The sorting is a two-level tournament. Candidates 0 to 17 and 18 to 35 each go to their own first-level selector. A selector compares every pair of its inputs in the same cycle, which is 153 comparators, and keeps the four inputs that fewer than four others beat. A merge selector then compares all pairs of the eight survivors, which is 28 comparators, and keeps the final four. Registers separate input capture, the first level and the merge. A new candidate set can be accepted on every clock, and each result appears at a fixed delay.

Top module: `best4_sorter`

## Requirements
- R1: The four output slots hold the four candidates with the largest 7-bit keys, compared as unsigned integers. Candidate k's key is `candKeys[k*7 +: 7]`, with momentum in bits 6:2 and quality in bits 1:0, so a larger momentum always beats a larger quality.
- R2: Slot 0 (rank bits 6:0, index bits 5:0) holds the strongest winner. Valid slots never increase in rank from slot s to slot s+1.
- R3: When keys are equal, the lower candidate number wins. This holds inside one half and across the two halves.
- R4: A zero key is invalid and never occupies a valid slot. If fewer than four valid candidates arrive, the remaining slots show valid 0, rank 0 and index 0. Valid slots always form a prefix starting at slot 0.
- R5: A candidate set present at rising edge n appears at the outputs after rising edge n+2. A different set may be presented on every edge.
- R6: While `rst` is high at a rising edge, all outputs become zero after that edge.
- R7: The index of a valid slot is the winner's candidate number, 0 to 35. No two valid slots carry the same index.
- R8: All four winners may come from a single half, for example all from candidates 18 to 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| candKeys | input | 252 | 36 keys; candidate k at bits k*7+6 down to k*7 |
| outRank | output | 28 | Winner keys; slot s at bits s*7+6 down to s*7 |
| outIdx | output | 24 | Winner candidate numbers; slot s at bits s*6+5 down to s*6 |
| outValid | output | 4 | Bit s is high when slot s holds a valid winner |

## Verification
The hardest case to reach from the ports is the tie-break at the merge. It needs equal keys in both halves, with the lower half holding more than one of them. Only then do the merge's position order and the first level's index order both affect the result. The stimulus reaches it with sets built for this case: equal keys at candidates 3, 17, 20 and 35, all 36 keys equal, and generated sets drawn from only two key values. All sets go in on consecutive clocks, so every result is also checked against a different neighbouring set one cycle on either side.

// File: rtl/best4_pkg.sv
package best4_pkg;
  localparam int NUM_CAND   = 36;
  localparam int KEY_W      = 7;
  localparam int NUM_WIN    = 4;
  localparam int NUM_GROUP  = 2;
  localparam int GROUP_SIZE = NUM_CAND / NUM_GROUP;
  localparam int MERGE_SIZE = NUM_GROUP * NUM_WIN;
  localparam int IDX_W      = $clog2(NUM_CAND);

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic [IDX_W-1:0] idx;
  } cand_t;

  localparam int CAND_W = $bits(cand_t);
endpackage

// File: rtl/best4_pipe.sv
module best4_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/best4_select.sv
module best4_select
  import best4_pkg::*;
#(
  parameter int N = 18
) (
  input  cand_t candIn [N],
  output cand_t winOut [NUM_WIN]
);
  localparam int CNT_W = $clog2(N + 1);

  // beatMat[i][j] is high when entry j outranks entry i
  logic [N-1:0][N-1:0] beatMat;
  logic [CNT_W-1:0]    lossCnt [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    assign beatMat[i][i] = 1'b0;
    for (genvar j = 0; j < i; j++) begin : g_pair
      // one comparator per pair; the lower position wins equal keys
      logic lowerWins;
      assign lowerWins     = candIn[j].key >= candIn[i].key;
      assign beatMat[i][j] = lowerWins;
      assign beatMat[j][i] = ~lowerWins;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lossCnt[i] = CNT_W'($countones(beatMat[i]));
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_WIN; s++) begin
      winOut[s] = '0;
      for (int i = 0; i < N; i++) begin
        if (lossCnt[i] == CNT_W'(s)) winOut[s] = candIn[i];
      end
      if (winOut[s].key == '0) winOut[s].idx = '0;
    end
  end
endmodule

// File: rtl/best4_sorter.sv
module best4_sorter
  import best4_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CAND*KEY_W-1:0]   candKeys,
  output logic [NUM_WIN*KEY_W-1:0]    outRank,
  output logic [NUM_WIN*IDX_W-1:0]    outIdx,
  output logic [NUM_WIN-1:0]          outValid
);
  localparam int IN_W  = NUM_CAND * KEY_W;
  localparam int MID_W = MERGE_SIZE * CAND_W;
  localparam int OUT_W = NUM_WIN * CAND_W;

  logic [IN_W-1:0]  keyQ;
  logic [MID_W-1:0] midD, midQ;
  logic [OUT_W-1:0] outD, outQ;

  best4_pipe #(.W(IN_W)) u_inReg (.clk(clk), .rst(rst), .d(candKeys), .q(keyQ));

  for (genvar g = 0; g < NUM_GROUP; g++) begin : g_group
    cand_t grpIn  [GROUP_SIZE];
    cand_t grpWin [NUM_WIN];
    for (genvar i = 0; i < GROUP_SIZE; i++) begin : g_in
      assign grpIn[i].key = keyQ[(g*GROUP_SIZE+i)*KEY_W +: KEY_W];
      assign grpIn[i].idx = IDX_W'(g*GROUP_SIZE + i);
    end
    best4_select #(.N(GROUP_SIZE)) u_sel (.candIn(grpIn), .winOut(grpWin));
    for (genvar s = 0; s < NUM_WIN; s++) begin : g_pack
      assign midD[(g*NUM_WIN+s)*CAND_W +: CAND_W] = grpWin[s];
    end
  end

  best4_pipe #(.W(MID_W)) u_midReg (.clk(clk), .rst(rst), .d(midD), .q(midQ));

  cand_t mergeIn  [MERGE_SIZE];
  cand_t mergeWin [NUM_WIN];

  for (genvar m = 0; m < MERGE_SIZE; m++) begin : g_mergeIn
    assign mergeIn[m] = midQ[m*CAND_W +: CAND_W];
  end

  best4_select #(.N(MERGE_SIZE)) u_merge (.candIn(mergeIn), .winOut(mergeWin));

  for (genvar s = 0; s < NUM_WIN; s++) begin : g_out
    cand_t slotQ;
    assign outD[s*CAND_W +: CAND_W] = mergeWin[s];
    assign slotQ                    = outQ[s*CAND_W +: CAND_W];
    assign outRank[s*KEY_W +: KEY_W] = slotQ.key;
    assign outIdx[s*IDX_W +: IDX_W]  = slotQ.idx;
    assign outValid[s]               = |slotQ.key;
  end

  best4_pipe #(.W(OUT_W)) u_outReg (.clk(clk), .rst(rst), .d(outD), .q(outQ));
endmodule

// File: rtl/best4_checker.sv
module best4_checker
  import best4_pkg::*;
(
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CAND*KEY_W-1:0] candKeys,
  input logic [NUM_WIN*KEY_W-1:0]  outRank,
  input logic [NUM_WIN*IDX_W-1:0]  outIdx,
  input logic [NUM_WIN-1:0]        outValid
);
  logic [1:0]       sinceRst;
  logic [KEY_W-1:0] maxIn;

  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= '0;
    else if (sinceRst != 3) sinceRst <= sinceRst + 2'd1;
  end

  always_comb begin
    maxIn = '0;
    for (int k = 0; k < NUM_CAND; k++) begin
      if (candKeys[k*KEY_W +: KEY_W] > maxIn) maxIn = candKeys[k*KEY_W +: KEY_W];
    end
  end

  // R5: slot 0 shows the largest key presented three edges earlier
  assert_latency_max_R5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 3) |-> (outRank[0 +: KEY_W] == $past(maxIn, 3)));

  // R6: a reset edge clears every output
  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (outValid == '0 && outRank == '0 && outIdx == '0));

  for (genvar s = 0; s < NUM_WIN; s++) begin : g_slot
    // R4: an invalid slot carries zero rank and zero index
    assert_empty_slot_R4: assert property (@(posedge clk) disable iff (rst)
      !outValid[s] |-> (outRank[s*KEY_W +: KEY_W] == '0 && outIdx[s*IDX_W +: IDX_W] == '0));
    // R7: a valid index names an existing candidate
    assert_index_range_R7: assert property (@(posedge clk) disable iff (rst)
      outValid[s] |-> (outIdx[s*IDX_W +: IDX_W] < IDX_W'(NUM_CAND)));
    if (s > 0) begin : g_adj
      // R4: valid slots form a prefix
      assert_valid_prefix_R4: assert property (@(posedge clk) disable iff (rst)
        outValid[s] |-> outValid[s-1]);
      // R2: ranks do not rise down the slots
      assert_rank_order_R2: assert property (@(posedge clk) disable iff (rst)
        outValid[s] |-> (outRank[(s-1)*KEY_W +: KEY_W] >= outRank[s*KEY_W +: KEY_W]));
      // R3: equal ranks appear in ascending candidate order
      assert_tie_order_R3: assert property (@(posedge clk) disable iff (rst)
        (outValid[s] && outRank[(s-1)*KEY_W +: KEY_W] == outRank[s*KEY_W +: KEY_W])
        |-> (outIdx[(s-1)*IDX_W +: IDX_W] < outIdx[s*IDX_W +: IDX_W]));
    end
    for (genvar t = s + 1; t < NUM_WIN; t++) begin : g_pairs
      // R7: no candidate fills two valid slots
      assert_distinct_idx_R7: assert property (@(posedge clk) disable iff (rst)
        (outValid[s] && outValid[t]) |-> (outIdx[s*IDX_W +: IDX_W] != outIdx[t*IDX_W +: IDX_W]));
    end
  end
endmodule

bind best4_sorter best4_checker u_chk (.*);

// File: tb/best4_sorter_bench.sv
module best4_sorter_bench;
  import best4_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W       = NUM_CAND * KEY_W;
  localparam int NTAB       = 10;
  localparam int NDIR       = 6;
  localparam int NSETS      = NTAB + NDIR;

  typedef struct packed {
    logic [31:0] seed;
    logic [31:0] mode;
  } vec_t;

  // mode: 0 random, 1 sparse, 2 two key values, 3 upper half dominant, 4 fixed momentum
  localparam vec_t TABLE [NTAB] = '{
    '{32'd11, 32'd0}, '{32'd907, 32'd0}, '{32'd35, 32'd1}, '{32'd4242, 32'd1},
    '{32'd7, 32'd2},  '{32'd5150, 32'd2}, '{32'd99, 32'd3}, '{32'd123, 32'd3},
    '{32'd61, 32'd4}, '{32'd2024, 32'd4}
  };

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [IN_W-1:0]          candKeys = '0;
  logic [NUM_WIN*KEY_W-1:0] outRank;
  logic [NUM_WIN*IDX_W-1:0] outIdx;
  logic [NUM_WIN-1:0]       outValid;

  logic [IN_W-1:0] sets [NSETS];
  string           tags [NSETS];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  best4_sorter u_best4_sorter (
    .clk(clk), .rst(rst), .candKeys(candKeys),
    .outRank(outRank), .outIdx(outIdx), .outValid(outValid)
  );

  function automatic logic [IN_W-1:0] genSet(input int unsigned seed, input int unsigned mode);
    logic [IN_W-1:0] ks;
    int unsigned x;
    int unsigned r;
    logic [KEY_W-1:0] key;
    ks = '0;
    x  = seed;
    for (int k = 0; k < NUM_CAND; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      r = x >> 16;
      case (mode)
        0: key = KEY_W'(r & 127);
        1: key = ((r % 6) == 0) ? KEY_W'((r >> 3) | 1) : '0;
        2: key = KEY_W'(80 + (r & 1));
        3: key = (k >= GROUP_SIZE) ? KEY_W'(((r >> 2) & 63) | 64) : KEY_W'((r >> 2) & 63);
        default: key = {5'd9, r[1:0]};
      endcase
      ks[k*KEY_W +: KEY_W] = key;
    end
    return ks;
  endfunction

  // reference: repeated pick of the strongest unused nonzero key, lower number first
  task automatic model(input logic [IN_W-1:0] ks, output logic [NUM_WIN*KEY_W-1:0] eRank,
                       output logic [NUM_WIN*IDX_W-1:0] eIdx, output logic [NUM_WIN-1:0] eVal);
    logic [NUM_CAND-1:0] taken;
    int best;
    logic [KEY_W-1:0] bestKey;
    taken = '0; eRank = '0; eIdx = '0; eVal = '0;
    for (int s = 0; s < NUM_WIN; s++) begin
      best = -1; bestKey = '0;
      for (int k = 0; k < NUM_CAND; k++) begin
        if (!taken[k] && ks[k*KEY_W +: KEY_W] > bestKey) begin
          best = k; bestKey = ks[k*KEY_W +: KEY_W];
        end
      end
      if (best >= 0) begin
        taken[best] = 1'b1;
        eRank[s*KEY_W +: KEY_W] = bestKey;
        eIdx[s*IDX_W +: IDX_W]  = IDX_W'(best);
        eVal[s] = 1'b1;
      end
    end
  endtask

  task automatic checkSet(input int v);
    logic [NUM_WIN*KEY_W-1:0] eRank;
    logic [NUM_WIN*IDX_W-1:0] eIdx;
    logic [NUM_WIN-1:0]       eVal;
    model(sets[v], eRank, eIdx, eVal);
    vectors++;
    if (outRank !== eRank || outIdx !== eIdx || outValid !== eVal) begin
      miscompares++;
      $display("FAIL %s set %0d: rank=%h idx=%h valid=%b expected rank=%h idx=%h valid=%b",
               tags[v], v, outRank, outIdx, outValid, eRank, eIdx, eVal);
    end
  endtask

  task automatic checkZero(input string what);
    vectors++;
    if (outRank !== '0 || outIdx !== '0 || outValid !== '0) begin
      miscompares++;
      $display("FAIL %s: rank=%h idx=%h valid=%b expected all zero", what, outRank, outIdx, outValid);
    end
  endtask

  function automatic string tagFor(input int unsigned mode);
    case (mode)
      0: return "R1 R5 R7 random";
      1: return "R4 R5 sparse";
      2: return "R3 R5 two-value ties";
      3: return "R8 R5 upper-half dominant";
      default: return "R1 R3 fixed momentum";
    endcase
  endfunction

  initial begin
    for (int t = 0; t < NTAB; t++) begin
      sets[t] = genSet(TABLE[t].seed, TABLE[t].mode);
      tags[t] = tagFor(TABLE[t].mode);
    end
    // directed corners
    sets[NTAB] = '0;                                   tags[NTAB]   = "R4 no valid candidate";
    sets[NTAB+1] = '0;
    sets[NTAB+1][7*KEY_W +: KEY_W]  = 7'h22;
    sets[NTAB+1][30*KEY_W +: KEY_W] = 7'h05;          tags[NTAB+1] = "R4 two valid";
    sets[NTAB+2] = '1;                                 tags[NTAB+2] = "R3 all equal";
    for (int k = 0; k < NUM_CAND; k++) sets[NTAB+3][k*KEY_W +: KEY_W] = 7'h01;
    sets[NTAB+3][3*KEY_W +: KEY_W]  = 7'h3C;
    sets[NTAB+3][17*KEY_W +: KEY_W] = 7'h3C;
    sets[NTAB+3][20*KEY_W +: KEY_W] = 7'h3C;
    sets[NTAB+3][35*KEY_W +: KEY_W] = 7'h3C;          tags[NTAB+3] = "R3 cross-half ties";
    for (int k = 0; k < NUM_CAND; k++) sets[NTAB+4][k*KEY_W +: KEY_W] = KEY_W'(k);
    tags[NTAB+4] = "R8 top four in upper half";
    sets[NTAB+5] = '0;
    sets[NTAB+5][0*KEY_W +: KEY_W] = {5'd3, 2'd3};
    sets[NTAB+5][1*KEY_W +: KEY_W] = {5'd4, 2'd0};
    sets[NTAB+5][2*KEY_W +: KEY_W] = {5'd3, 2'd2};    tags[NTAB+5] = "R1 momentum over quality";

    repeat (3) @(posedge clk);
    @(negedge clk);
    checkZero("R6 outputs during reset");
    rst = 1'b0;
    // back-to-back stream: set c drives at negedge c, its result is sampled at negedge c+3
    for (int c = 0; c < NSETS + 3; c++) begin
      @(negedge clk);
      if (c >= 3) checkSet(c - 3);
      if (c < NSETS) candKeys = sets[c];
    end
    candKeys = sets[0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkSet(0);
    rst = 1'b1;
    @(negedge clk);
    checkZero("R6 reset after activity");
    rst = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule